// File: doc/BRIEF.md
# UART FIFO Trigger-Level Interrupt Controller

This block tracks how many characters sit in the transmit and receive FIFOs of one 64-deep UART channel and raises two interrupt requests. The receive request says the receive FIFO holds at least a chosen number of characters. The transmit request says the host should refill the transmit FIFO. The FIFO data storage, the serial shifters and the bus decoding are outside the block. It sees only push and pop strobes, and it exposes the resulting levels.

Software writes three things. The first is a FIFO control byte: two self-clearing reset bits, a stored DMA mode bit, and a 2-bit trigger code for each direction. The second is a 2-bit table select. The third is a pair of programmable 6-bit trigger values. The table select picks one of four threshold tables, and each direction's code indexes into that table. Table 3 uses the programmable values instead of fixed constants.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: With table select 0, receive codes 0,1,2,3 give receive triggers 1,4,8,14, and the transmit trigger is 1 for every code.
- R2: With table select 1, receive codes 0..3 give 8,16,24,28, and transmit codes 0..3 give 16,8,24,30.
- R3: With table select 2, receive codes 0..3 give 8,16,56,60, and transmit codes 0..3 give 8,16,32,56.
- R4: With table select 3, each trigger is the value last written to that direction's programmable register. Both registers reset to 1, and a written value of 0 acts as 1.
- R5: `rx_irq` is high exactly when `rx_level` is at or above the receive trigger, so a pop that brings the level below the trigger drops it.
- R6: A transmit pop that takes the level below the transmit trigger raises `tx_irq`, provided the level reached the trigger at or after the last refill began.
- R7: If the level never reached the trigger since the last refill began, `tx_irq` rises only when a pop empties the FIFO. Any accepted transmit push clears `tx_irq`.
- R8: A control write with bit 2 set clears the transmit level and raises `tx_irq` on the next edge. `tx_rst_ack` and `cfg_rd[2]` then read 1 for exactly one cycle and then 0.
- R9: A control write with bit 1 set clears the receive level on the next edge. `rx_rst_ack` and `cfg_rd[1]` then read 1 for one cycle and then 0.
- R10: A push to a FIFO holding 64 entries, or a pop from an empty FIFO, leaves the level unchanged.
- R11: Control bit 3 (DMA mode) is stored and read back on `cfg_rd[3]` but changes no trigger or interrupt. Control bits [7:6] hold the receive code and bits [5:4] hold the transmit code.
- R12: After reset, both levels, both interrupts, both acknowledgements, `cfg_rd` and the table select are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the FIFO control byte |
| cfg_data | input | 8 | Control byte: [7:6] rx code, [5:4] tx code, [3] DMA mode, [2] tx reset, [1] rx reset, [0] stored |
| cfg_rd | output | 8 | Control byte readback; the reset bits self-clear |
| tbl_wr | input | 1 | Write strobe for the table select |
| tbl_data | input | 2 | Table select value |
| prog_tx_wr | input | 1 | Write strobe for the programmable transmit trigger |
| prog_rx_wr | input | 1 | Write strobe for the programmable receive trigger |
| prog_data | input | 6 | Programmable trigger value |
| tx_push | input | 1 | Host wrote a character into the transmit FIFO |
| tx_pop | input | 1 | Shifter took a character from the transmit FIFO |
| rx_push | input | 1 | Shifter placed a character into the receive FIFO |
| rx_pop | input | 1 | Host read a character from the receive FIFO |
| tx_irq | output | 1 | Transmit refill request |
| rx_irq | output | 1 | Receive data-available request |
| tx_level | output | 7 | Transmit FIFO occupancy |
| rx_level | output | 7 | Receive FIFO occupancy |
| tx_rst_ack | output | 1 | One-cycle pulse after a transmit FIFO reset |
| rx_rst_ack | output | 1 | One-cycle pulse after a receive FIFO reset |

## Verification
Some properties are checked on every cycle. A level never passes 64. A full push or an empty pop leaves the level alone. A FIFO reset empties the level, and the acknowledge pulse lasts one cycle. Every rise of `tx_irq` follows a pop or a reset, and `rx_irq` never shows on an empty FIFO. The threshold values themselves can only be shown by the bench's scenarios. For each table and code, the bench fills to one below the trigger and then one more, and it drains a transmit FIFO across its trigger. It also covers the empty-after-short-refill case and the programmable table.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;

    // Control byte layout; field order is the bit order of the written byte.
    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       dma_mode;
        logic       tx_rst;
        logic       rx_rst;
        logic       spare;
    } fifo_ctrl_t;

    typedef struct packed {
        fifo_ctrl_t ctrl;
        logic [1:0] tbl;
    } ctrl_state_t;

    typedef struct packed {
        logic irq;
        logic reached;
    } tx_irq_state_t;

    localparam int NUM_DIR = 2;
    localparam int DIR_RX  = 0;
    localparam int DIR_TX  = 1;

endpackage

// File: rtl/uart_fifo_level.sv
module uart_fifo_level #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          push_ok, pop_ok;

    always_comb begin
        push_ok = push && (cnt_q < FULL);
        pop_ok  = pop && (cnt_q != '0);
        cnt_d   = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   cnt_d = cnt_q + 1'b1;
                2'b01:   cnt_d = cnt_q - 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign cnt_nxt = cnt_d;

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R10
    full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL && push && !pop && !clr) |=> cnt_q == FULL);

    // R10
    empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && pop && !push && !clr) |=> cnt_q == '0);

    // R8
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/uart_trig_lut.sv
module uart_trig_lut #(
    parameter int CW    = 7,
    parameter int PW    = 6,
    parameter bit IS_TX = 1'b0
) (
    input  logic [1:0]    tbl,
    input  logic [1:0]    code,
    input  logic [PW-1:0] prog,
    output logic [CW-1:0] trig
);
    logic [CW-1:0] prog_eff;

    assign prog_eff = (prog == '0) ? CW'(1) : CW'(prog);

    generate
        if (IS_TX) begin : g_tx
            always_comb begin
                trig = CW'(1);
                case (tbl)
                    2'd0: trig = CW'(1);
                    2'd1: case (code)
                              2'd0: trig = CW'(16);
                              2'd1: trig = CW'(8);
                              2'd2: trig = CW'(24);
                              default: trig = CW'(30);
                          endcase
                    2'd2: case (code)
                              2'd0: trig = CW'(8);
                              2'd1: trig = CW'(16);
                              2'd2: trig = CW'(32);
                              default: trig = CW'(56);
                          endcase
                    default: trig = prog_eff;
                endcase
            end
        end else begin : g_rx
            always_comb begin
                trig = CW'(1);
                case (tbl)
                    2'd0: case (code)
                              2'd0: trig = CW'(1);
                              2'd1: trig = CW'(4);
                              2'd2: trig = CW'(8);
                              default: trig = CW'(14);
                          endcase
                    2'd1: case (code)
                              2'd0: trig = CW'(8);
                              2'd1: trig = CW'(16);
                              2'd2: trig = CW'(24);
                              default: trig = CW'(28);
                          endcase
                    2'd2: case (code)
                              2'd0: trig = CW'(8);
                              2'd1: trig = CW'(16);
                              2'd2: trig = CW'(56);
                              default: trig = CW'(60);
                          endcase
                    default: trig = prog_eff;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/uart_tx_irq_gen.sv
module uart_tx_irq_gen
    import uart_trig_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [CW-1:0] trig,
    output logic          irq
);
    tx_irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.irq     = 1'b1;
            st_d.reached = 1'b0;
        end else if (cnt_nxt > cnt) begin
            st_d.irq = 1'b0;
            if (cnt_nxt >= trig) st_d.reached = 1'b1;
        end else if (cnt_nxt < cnt) begin
            if (st_q.reached && (cnt_nxt < trig)) begin
                st_d.irq     = 1'b1;
                st_d.reached = 1'b0;
            end else if (!st_q.reached && (cnt_nxt == '0)) begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R6
    tx_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(clr) || ($past(cnt_nxt) < $past(cnt))));

    // R7
    tx_push_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_nxt > cnt) |=> !irq);

endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
    import uart_trig_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_data,
    output logic [7:0]    cfg_rd,
    input  logic          tbl_wr,
    input  logic [1:0]    tbl_data,
    input  logic          prog_tx_wr,
    input  logic          prog_rx_wr,
    input  logic [PW-1:0] prog_data,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic          rx_push,
    input  logic          rx_pop,
    output logic          tx_irq,
    output logic          rx_irq,
    output logic [CW-1:0] tx_level,
    output logic [CW-1:0] rx_level,
    output logic          tx_rst_ack,
    output logic          rx_rst_ack
);
    ctrl_state_t   cs_d, cs_q;
    logic [PW-1:0] prog_d [NUM_DIR];
    logic [PW-1:0] prog_q [NUM_DIR];
    fifo_ctrl_t    wr_byte;

    logic          clr   [NUM_DIR];
    logic          push  [NUM_DIR];
    logic          pop   [NUM_DIR];
    logic [1:0]    code  [NUM_DIR];
    logic [CW-1:0] cnt   [NUM_DIR];
    logic [CW-1:0] cnt_n [NUM_DIR];
    logic [CW-1:0] trig  [NUM_DIR];

    assign wr_byte = fifo_ctrl_t'(cfg_data);

    always_comb begin
        cs_d = cs_q;
        cs_d.ctrl.tx_rst = 1'b0;
        cs_d.ctrl.rx_rst = 1'b0;
        if (cfg_wr) cs_d.ctrl = wr_byte;
        if (tbl_wr) cs_d.tbl  = tbl_data;
        prog_d[DIR_TX] = prog_tx_wr ? prog_data : prog_q[DIR_TX];
        prog_d[DIR_RX] = prog_rx_wr ? prog_data : prog_q[DIR_RX];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q           <= '0;
            prog_q[DIR_TX] <= PW'(1);
            prog_q[DIR_RX] <= PW'(1);
        end else begin
            cs_q           <= cs_d;
            prog_q[DIR_TX] <= prog_d[DIR_TX];
            prog_q[DIR_RX] <= prog_d[DIR_RX];
        end
    end

    assign clr[DIR_TX]  = cfg_wr && wr_byte.tx_rst;
    assign clr[DIR_RX]  = cfg_wr && wr_byte.rx_rst;
    assign push[DIR_TX] = tx_push;
    assign push[DIR_RX] = rx_push;
    assign pop[DIR_TX]  = tx_pop;
    assign pop[DIR_RX]  = rx_pop;
    assign code[DIR_TX] = cs_q.ctrl.tx_code;
    assign code[DIR_RX] = cs_q.ctrl.rx_code;

    generate
        for (genvar i = 0; i < NUM_DIR; i++) begin : g_dir
            uart_fifo_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr[i]),
                .push    (push[i]),
                .pop     (pop[i]),
                .cnt     (cnt[i]),
                .cnt_nxt (cnt_n[i])
            );
            uart_trig_lut #(.CW(CW), .PW(PW), .IS_TX(i == DIR_TX)) u_lut (
                .tbl  (cs_q.tbl),
                .code (code[i]),
                .prog (prog_q[i]),
                .trig (trig[i])
            );
        end
    endgenerate

    uart_tx_irq_gen #(.CW(CW)) u_tx_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr[DIR_TX]),
        .cnt     (cnt[DIR_TX]),
        .cnt_nxt (cnt_n[DIR_TX]),
        .trig    (trig[DIR_TX]),
        .irq     (tx_irq)
    );

    assign rx_irq     = cnt[DIR_RX] >= trig[DIR_RX];
    assign tx_level   = cnt[DIR_TX];
    assign rx_level   = cnt[DIR_RX];
    assign cfg_rd     = cs_q.ctrl;
    assign tx_rst_ack = cs_q.ctrl.tx_rst;
    assign rx_rst_ack = cs_q.ctrl.rx_rst;

    // R8
    tx_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rst_ack && !clr[DIR_TX]) |=> !tx_rst_ack);

    // R9
    rx_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rst_ack && !clr[DIR_RX]) |=> !rx_rst_ack);

    // R5
    rx_irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_level != '0);

    // R4
    trig_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[DIR_TX] != '0) && (trig[DIR_RX] != '0));

    // R10
    rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr[DIR_RX] |-> ((cnt_n[DIR_RX] == rx_level) ||
                          (cnt_n[DIR_RX] == rx_level + 1'b1) ||
                          (cnt_n[DIR_RX] == rx_level - 1'b1)));

endmodule

// File: tb/tb_uart_fifo_irq_ctrl.sv
module tb_uart_fifo_irq_ctrl;
    localparam int DEPTH = 64;
    localparam int CW    = 7;
    localparam int PW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_data = '0;
    logic [7:0]    cfg_rd;
    logic          tbl_wr = 1'b0;
    logic [1:0]    tbl_data = '0;
    logic          prog_tx_wr = 1'b0;
    logic          prog_rx_wr = 1'b0;
    logic [PW-1:0] prog_data = '0;
    logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic          tx_irq, rx_irq, tx_rst_ack, rx_rst_ack;
    logic [CW-1:0] tx_level, rx_level;

    always #4 clk = ~clk;

    uart_fifo_irq_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .cfg_rd(cfg_rd), .tbl_wr(tbl_wr), .tbl_data(tbl_data),
        .prog_tx_wr(prog_tx_wr), .prog_rx_wr(prog_rx_wr), .prog_data(prog_data),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_level(tx_level), .rx_level(rx_level),
        .tx_rst_ack(tx_rst_ack), .rx_rst_ack(rx_rst_ack)
    );

    typedef enum int {S_RXIRQ, S_TXIRQ, S_RXLVL, S_TXLVL, S_RXACK, S_TXACK, S_CFG} sel_e;
    typedef struct {
        string req;
        sel_e  sel;
        int    exp;
    } item_t;

    item_t q[$];
    event  ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    function automatic int peek(sel_e s);
        case (s)
            S_RXIRQ: return int'(rx_irq);
            S_TXIRQ: return int'(tx_irq);
            S_RXLVL: return int'(rx_level);
            S_TXLVL: return int'(tx_level);
            S_RXACK: return int'(rx_rst_ack);
            S_TXACK: return int'(tx_rst_ack);
            default: return int'(cfg_rd);
        endcase
    endfunction

    // Monitor: drains the scoreboard queue and compares against the ports.
    initial begin
        forever begin
            @(ev);
            while (q.size() > 0) begin
                item_t it;
                int act;
                it  = q.pop_front();
                act = peek(it.sel);
                n_cmp++;
                if (act != it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s actual=%0d expected=%0d", it.req, it.sel.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(input string r, input sel_e s, input int v);
        item_t it;
        it.req = r; it.sel = s; it.exp = v;
        q.push_back(it);
        ->ev;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] b);
        cfg_wr = 1'b1; cfg_data = b; tick(); cfg_wr = 1'b0;
    endtask

    task automatic wr_tbl(input int t);
        tbl_wr = 1'b1; tbl_data = 2'(t); tick(); tbl_wr = 1'b0;
    endtask

    task automatic wr_prog(input bit is_tx, input int v);
        prog_data = PW'(v);
        if (is_tx) prog_tx_wr = 1'b1; else prog_rx_wr = 1'b1;
        tick();
        prog_tx_wr = 1'b0; prog_rx_wr = 1'b0;
    endtask

    task automatic push(input bit is_tx, input int n);
        for (int i = 0; i < n; i++) begin
            if (is_tx) tx_push = 1'b1; else rx_push = 1'b1;
            tick();
            tx_push = 1'b0; rx_push = 1'b0;
        end
    endtask

    task automatic pop(input bit is_tx, input int n);
        for (int i = 0; i < n; i++) begin
            if (is_tx) tx_pop = 1'b1; else rx_pop = 1'b1;
            tick();
            tx_pop = 1'b0; rx_pop = 1'b0;
        end
    endtask

    // Expected thresholds, taken from the requirement text.
    function automatic int rx_ref(input int t, input int c, input int p);
        int r1 [4] = '{1, 4, 8, 14};
        int r2 [4] = '{8, 16, 24, 28};
        int r3 [4] = '{8, 16, 56, 60};
        case (t)
            0: return r1[c];
            1: return r2[c];
            2: return r3[c];
            default: return (p == 0) ? 1 : p;
        endcase
    endfunction

    function automatic int tx_ref(input int t, input int c, input int p);
        int t2 [4] = '{16, 8, 24, 30};
        int t3 [4] = '{8, 16, 32, 56};
        case (t)
            0: return 1;
            1: return t2[c];
            2: return t3[c];
            default: return (p == 0) ? 1 : p;
        endcase
    endfunction

    function automatic string tag(input int t);
        string n [4] = '{"R1", "R2", "R3", "R4"};
        return n[t];
    endfunction

    task automatic rx_case(input int t, input int c, input int lvl);
        wr_tbl(t);
        wr_cfg({2'(c), 2'b00, 1'b0, 1'b0, 1'b1, 1'b0});
        if (lvl > 1) push(1'b0, lvl - 1);
        expect_v(tag(t), S_RXIRQ, 0);
        push(1'b0, 1);
        expect_v(tag(t), S_RXIRQ, 1);
        expect_v(tag(t), S_RXLVL, lvl);
        pop(1'b0, 1);
        expect_v("R5", S_RXIRQ, 0);
    endtask

    task automatic tx_case(input int t, input int c, input int lvl);
        wr_tbl(t);
        wr_cfg({2'b00, 2'(c), 1'b0, 1'b1, 1'b0, 1'b0});
        push(1'b1, 60);
        pop(1'b1, 60 - lvl);
        expect_v(tag(t), S_TXIRQ, 0);
        expect_v(tag(t), S_TXLVL, lvl);
        pop(1'b1, 1);
        expect_v("R6", S_TXIRQ, 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R12 reset state
        expect_v("R12", S_RXLVL, 0);
        expect_v("R12", S_TXLVL, 0);
        expect_v("R12", S_RXIRQ, 0);
        expect_v("R12", S_TXIRQ, 0);
        expect_v("R12", S_RXACK, 0);
        expect_v("R12", S_TXACK, 0);
        expect_v("R12", S_CFG, 0);

        // R4: programmable table with reset values
        rx_case(3, 0, 1);
        tx_case(3, 0, 1);

        // R1, R2, R3: every table and code
        for (int t = 0; t < 3; t++) begin
            for (int c = 0; c < 4; c++) begin
                rx_case(t, c, rx_ref(t, c, 0));
                tx_case(t, c, tx_ref(t, c, 0));
            end
        end

        // R4: programmed values, zero acting as one
        wr_prog(1'b0, 0);
        rx_case(3, 1, rx_ref(3, 1, 0));
        wr_prog(1'b0, 20);
        rx_case(3, 2, rx_ref(3, 2, 20));
        wr_prog(1'b1, 33);
        tx_case(3, 1, tx_ref(3, 1, 33));
        wr_prog(1'b1, 0);
        tx_case(3, 3, tx_ref(3, 3, 0));

        // R7: short refill, interrupt only on empty
        wr_tbl(1);
        wr_cfg(8'h04);
        expect_v("R8", S_TXIRQ, 1);
        push(1'b1, 3);
        expect_v("R7", S_TXIRQ, 0);
        pop(1'b1, 2);
        expect_v("R7", S_TXIRQ, 0);
        expect_v("R7", S_TXLVL, 1);
        pop(1'b1, 1);
        expect_v("R7", S_TXIRQ, 1);

        // R8: transmit FIFO reset
        push(1'b1, 5);
        expect_v("R8", S_TXIRQ, 0);
        wr_cfg(8'h04);
        expect_v("R8", S_TXLVL, 0);
        expect_v("R8", S_TXACK, 1);
        expect_v("R8", S_CFG, 8'h04);
        expect_v("R8", S_TXIRQ, 1);
        tick();
        expect_v("R8", S_TXACK, 0);
        expect_v("R8", S_CFG, 8'h00);

        // R9: receive FIFO reset
        wr_tbl(0);
        push(1'b0, 5);
        expect_v("R9", S_RXIRQ, 1);
        wr_cfg(8'h02);
        expect_v("R9", S_RXLVL, 0);
        expect_v("R9", S_RXACK, 1);
        expect_v("R9", S_RXIRQ, 0);
        tick();
        expect_v("R9", S_RXACK, 0);
        expect_v("R9", S_CFG, 8'h00);

        // R10: full push and empty pop ignored
        wr_cfg(8'h06);
        push(1'b1, 65);
        expect_v("R10", S_TXLVL, 64);
        pop(1'b0, 1);
        expect_v("R10", S_RXLVL, 0);
        push(1'b0, 66);
        expect_v("R10", S_RXLVL, 64);
        pop(1'b0, 66);
        expect_v("R10", S_RXLVL, 0);

        // R11: DMA bit stored, no effect on receive threshold (table 1, code 1 -> 16)
        wr_tbl(1);
        wr_cfg(8'h4A);
        tick();
        expect_v("R11", S_CFG, 8'h48);
        push(1'b0, 15);
        expect_v("R11", S_RXIRQ, 0);
        push(1'b0, 1);
        expect_v("R11", S_RXIRQ, 1);

        tick();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule